// File: doc/BRIEF.md
# Store Queue Memory Disambiguator

This block holds outstanding stores in program order and decides, for each load whose address has just become known, how that load may proceed. A store takes a slot at the tail when it is allocated, along with the reorder-buffer tag of the instruction that will produce its data. Its address and its data arrive later, each on its own fill port, in either order. Each fill names the slot it belongs to. Stores leave from the head, one at a time, when the commit logic accepts them on the dequeue stream. A store is offered there only once both its address and its data are present.

A load records the tail pointer, including the wrap bit, at the moment it dispatches. When it presents its address together with that recorded pointer, the block looks only at stores between the head and the recorded pointer. It answers in the same cycle with one of four result codes:
- stall, when one of those older stores has no address yet;
- forward the data of the youngest matching older store;
- forward the producer tag of that store when its data is still missing;
- go to memory, when no older store matches.

The allocate port and the dequeue port are valid/ready streams. An allocation is accepted in a cycle where `alloc_valid` and `alloc_ready` are both high, and `alloc_ready` is low while every slot is taken. A store leaves in a cycle where `deq_valid` and `deq_ready` are both high. While `deq_valid` is high and the consumer holds `deq_ready` low, the offered store and its fields stay unchanged. The fills and the load query are plain control pins with no back-pressure.

Top module: `store_disambig_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready`=1, `deq_valid`=0, `tail_ptr`=0, and with `ld_valid`=0 the result code is 0 (memory).
- R2: An accepted allocation advances `tail_ptr` by one, modulo 2*DEPTH. `alloc_ready` is 0 while DEPTH stores are held, and an allocation offered then is ignored, leaving `tail_ptr` unchanged. The slot of a store is `tail_ptr` modulo DEPTH at allocation.
- R3: `deq_valid` is 1 only when the head store has both address and data, with `deq_addr`/`deq_data` taken from that head store. Stores leave strictly in allocation order.
- R4: The result code is 3 (stall) when any store older than the load has no address, even if another older store matches. Stores younger than the load never cause a stall.
- R5: The result code is 1 (forward value) when an older store matches the load address and its data is present. `ld_data` then carries that data.
- R6: The result code is 2 (forward tag) when the selected matching older store has no data yet. `ld_tag` then carries the producer tag given at allocation.
- R7: The result code is 0 (memory) when no older store matches. Stores at or beyond the recorded tail, and stores already dequeued, are not considered.
- R8: When several older stores match, the youngest of them that is still older than the load is selected.
- R9: Age comparison stays correct after the pointers wrap past the end of the slot array.
- R10: The query answer is combinational on the state held before the current clock edge. An address or data fill presented in the same cycle is visible only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Store allocation request |
| alloc_ready | output | 1 | A free slot exists |
| alloc_tag | input | TAGW | Reorder-buffer tag of the store's data producer |
| tail_ptr | output | PTRW | Tail pointer with wrap bit; allocation position and load age stamp |
| addr_valid | input | 1 | Address fill strobe |
| addr_slot | input | IDXW | Slot receiving the address |
| addr_value | input | AW | Store address |
| data_valid | input | 1 | Data fill strobe |
| data_slot | input | IDXW | Slot receiving the data |
| data_value | input | DW | Store data |
| ld_valid | input | 1 | Load query present |
| ld_tail | input | PTRW | Tail pointer recorded when the load dispatched |
| ld_addr | input | AW | Load address |
| ld_result | output | 2 | 0 memory, 1 forward value, 2 forward tag, 3 stall |
| ld_data | output | DW | Forwarded data (zero unless code 1) |
| ld_tag | output | TAGW | Forwarded producer tag (zero unless code 2) |
| deq_valid | output | 1 | Head store is complete and offered |
| deq_ready | input | 1 | Commit accepts the head store |
| deq_addr | output | AW | Head store address |
| deq_data | output | DW | Head store data |

## Verification
The hardest situation to reach is a load query in which the range of older stores straddles the end of the slot array. Several stores in that range carry the same address, so only the wrap-bit arithmetic separates the youngest older match from the wrong one. The bench first pushes four stores through and dequeues them, which parks the head in the middle of the array. It then fills all eight slots with stores to one address and distinct data. Finally it queries with recorded tails on both sides of the wrap, plus one equal to the head, and checks which data value comes back.

// File: rtl/sdq_pkg.sv
package sdq_pkg;

  typedef enum logic [1:0] {
    LDR_MEM   = 2'd0,
    LDR_VAL   = 2'd1,
    LDR_TAG   = 2'd2,
    LDR_STALL = 2'd3
  } ld_res_e;

endpackage

// File: rtl/sdq_ptrs.sv
module sdq_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PTRW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  output logic [PTRW-1:0] head,
  output logic [PTRW-1:0] tail,
  output logic [PTRW-1:0] count,
  output logic            full
);

  localparam logic [PTRW-1:0] FULL_CNT = PTRW'(DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
    end
  end

  always_comb begin
    count = tail - head;
    full  = (count == FULL_CNT);
  end

endmodule

// File: rtl/sdq_entries.sv
module sdq_entries #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int TAGW  = 6,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_en,
  input  logic [IDXW-1:0]            alloc_slot,
  input  logic [TAGW-1:0]            alloc_tag,
  input  logic                       afill_en,
  input  logic [IDXW-1:0]            afill_slot,
  input  logic [AW-1:0]              afill_value,
  input  logic                       dfill_en,
  input  logic [IDXW-1:0]            dfill_slot,
  input  logic [DW-1:0]              dfill_value,
  output logic [DEPTH-1:0]           addr_ok,
  output logic [DEPTH-1:0]           data_ok,
  output logic [DEPTH-1:0][AW-1:0]   addr_q,
  output logic [DEPTH-1:0][DW-1:0]   data_q,
  output logic [DEPTH-1:0][TAGW-1:0] tag_q
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [IDXW-1:0] ME = IDXW'(g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_ok[g] <= 1'b0;
        data_ok[g] <= 1'b0;
        addr_q[g]  <= '0;
        data_q[g]  <= '0;
        tag_q[g]   <= '0;
      end else begin
        if (afill_en && afill_slot == ME) begin
          addr_ok[g] <= 1'b1;
          addr_q[g]  <= afill_value;
        end
        if (dfill_en && dfill_slot == ME) begin
          data_ok[g] <= 1'b1;
          data_q[g]  <= dfill_value;
        end
        if (alloc_en && alloc_slot == ME) begin
          addr_ok[g] <= 1'b0;
          data_ok[g] <= 1'b0;
          tag_q[g]   <= alloc_tag;
        end
      end
    end
  end

endmodule

// File: rtl/sdq_search.sv
module sdq_search
  import sdq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int TAGW  = 6,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PTRW = IDXW + 1
) (
  input  logic                       q_valid,
  input  logic [PTRW-1:0]            q_tail,
  input  logic [AW-1:0]              q_addr,
  input  logic [PTRW-1:0]            head,
  input  logic [PTRW-1:0]            count,
  input  logic [DEPTH-1:0]           addr_ok,
  input  logic [DEPTH-1:0]           data_ok,
  input  logic [DEPTH-1:0][AW-1:0]   addr_q,
  input  logic [DEPTH-1:0][DW-1:0]   data_q,
  input  logic [DEPTH-1:0][TAGW-1:0] tag_q,
  output ld_res_e                    res,
  output logic [DW-1:0]              res_data,
  output logic [TAGW-1:0]            res_tag
);

  logic [PTRW-1:0] span;
  logic [PTRW-1:0] n_older;
  logic            any_unknown;
  logic            any_hit;
  logic [IDXW-1:0] sel;

  always_comb begin
    span    = q_tail - head;
    // a head that has moved past the recorded tail leaves no older store
    n_older = (span <= count) ? span : '0;
    any_unknown = 1'b0;
    any_hit     = 1'b0;
    sel         = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [IDXW-1:0] slot;
      slot = head[IDXW-1:0] + IDXW'(k);
      if (PTRW'(k) < n_older) begin
        if (!addr_ok[slot]) begin
          any_unknown = 1'b1;
        end else if (addr_q[slot] == q_addr) begin
          any_hit = 1'b1;
          sel     = slot;   // later k is younger, so the last hit wins
        end
      end
    end
  end

  always_comb begin
    res      = LDR_MEM;
    res_data = '0;
    res_tag  = '0;
    if (q_valid) begin
      if (any_unknown) begin
        res = LDR_STALL;
      end else if (any_hit) begin
        if (data_ok[sel]) begin
          res      = LDR_VAL;
          res_data = data_q[sel];
        end else begin
          res     = LDR_TAG;
          res_tag = tag_q[sel];
        end
      end
    end
  end

endmodule

// File: rtl/store_disambig_queue.sv
module store_disambig_queue
  import sdq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int TAGW  = 6,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PTRW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_valid,
  output logic            alloc_ready,
  input  logic [TAGW-1:0] alloc_tag,
  output logic [PTRW-1:0] tail_ptr,
  input  logic            addr_valid,
  input  logic [IDXW-1:0] addr_slot,
  input  logic [AW-1:0]   addr_value,
  input  logic            data_valid,
  input  logic [IDXW-1:0] data_slot,
  input  logic [DW-1:0]   data_value,
  input  logic            ld_valid,
  input  logic [PTRW-1:0] ld_tail,
  input  logic [AW-1:0]   ld_addr,
  output logic [1:0]      ld_result,
  output logic [DW-1:0]   ld_data,
  output logic [TAGW-1:0] ld_tag,
  output logic            deq_valid,
  input  logic            deq_ready,
  output logic [AW-1:0]   deq_addr,
  output logic [DW-1:0]   deq_data
);

  logic [PTRW-1:0]           head, tail, count;
  logic                      full, push, pop;
  logic [DEPTH-1:0]          addr_ok, data_ok;
  logic [DEPTH-1:0][AW-1:0]  addr_q;
  logic [DEPTH-1:0][DW-1:0]  data_q;
  logic [DEPTH-1:0][TAGW-1:0] tag_q;
  ld_res_e                   res;
  logic [IDXW-1:0]           head_idx;

  assign alloc_ready = !full;
  assign push        = alloc_valid && alloc_ready;
  assign pop         = deq_valid && deq_ready;
  assign tail_ptr    = tail;
  assign head_idx    = head[IDXW-1:0];

  sdq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .head(head), .tail(tail), .count(count), .full(full)
  );

  sdq_entries #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TAGW(TAGW)) u_entries (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(push), .alloc_slot(tail[IDXW-1:0]), .alloc_tag(alloc_tag),
    .afill_en(addr_valid), .afill_slot(addr_slot), .afill_value(addr_value),
    .dfill_en(data_valid), .dfill_slot(data_slot), .dfill_value(data_value),
    .addr_ok(addr_ok), .data_ok(data_ok),
    .addr_q(addr_q), .data_q(data_q), .tag_q(tag_q)
  );

  sdq_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TAGW(TAGW)) u_search (
    .q_valid(ld_valid), .q_tail(ld_tail), .q_addr(ld_addr),
    .head(head), .count(count),
    .addr_ok(addr_ok), .data_ok(data_ok),
    .addr_q(addr_q), .data_q(data_q), .tag_q(tag_q),
    .res(res), .res_data(ld_data), .res_tag(ld_tag)
  );

  assign ld_result = res;

  always_comb begin
    deq_valid = (count != '0) && addr_ok[head_idx] && data_ok[head_idx];
    deq_addr  = addr_q[head_idx];
    deq_data  = data_q[head_idx];
  end

endmodule

// File: rtl/sdq_checker.sv
module sdq_checker #(
  parameter int PTRW = 4,
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int TAGW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            alloc_valid,
  input logic            alloc_ready,
  input logic [PTRW-1:0] tail_ptr,
  input logic            addr_valid,
  input logic            data_valid,
  input logic            ld_valid,
  input logic [1:0]      ld_result,
  input logic [DW-1:0]   ld_data,
  input logic [TAGW-1:0] ld_tag,
  input logic            deq_valid,
  input logic            deq_ready,
  input logic [AW-1:0]   deq_addr,
  input logic [DW-1:0]   deq_data
);

  a_r2_tail_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> tail_ptr == $past(tail_ptr) + 1'b1);

  a_r2_tail_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_valid && alloc_ready) |=> $stable(tail_ptr));

  a_r2_space_after_deq: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && deq_ready) |=> alloc_ready);

  a_r3_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && !deq_ready && !addr_valid && !data_valid)
      |=> deq_valid && $stable(deq_addr) && $stable(deq_data));

  a_r4_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_result == 2'd3) |-> (ld_data == '0 && ld_tag == '0));

  a_r10_idle_memory: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> ld_result == 2'd0);

endmodule

bind store_disambig_queue sdq_checker #(
  .PTRW(PTRW), .AW(AW), .DW(DW), .TAGW(TAGW)
) u_sdq_checker (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .tail_ptr(tail_ptr), .addr_valid(addr_valid), .data_valid(data_valid),
  .ld_valid(ld_valid), .ld_result(ld_result), .ld_data(ld_data), .ld_tag(ld_tag),
  .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_addr(deq_addr), .deq_data(deq_data)
);

// File: tb/test_store_disambig_queue.sv
module test_store_disambig_queue;

  localparam int CLK_P = 10;
  localparam int DEPTH = 8;
  localparam int AW = 16, DW = 32, TAGW = 6;
  localparam int IDXW = $clog2(DEPTH);
  localparam int PTRW = IDXW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0, alloc_ready;
  logic [TAGW-1:0] alloc_tag = '0;
  logic [PTRW-1:0] tail_ptr;
  logic addr_valid = 0, data_valid = 0, ld_valid = 0, deq_ready = 0, deq_valid;
  logic [IDXW-1:0] addr_slot = '0, data_slot = '0;
  logic [AW-1:0] addr_value = '0, ld_addr = '0, deq_addr;
  logic [DW-1:0] data_value = '0, ld_data, deq_data;
  logic [PTRW-1:0] ld_tail = '0;
  logic [1:0] ld_result;
  logic [TAGW-1:0] ld_tag;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  store_disambig_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TAGW(TAGW)) i_store_disambig_queue (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_tag(alloc_tag), .tail_ptr(tail_ptr), .addr_valid(addr_valid),
    .addr_slot(addr_slot), .addr_value(addr_value), .data_valid(data_valid),
    .data_slot(data_slot), .data_value(data_value), .ld_valid(ld_valid),
    .ld_tail(ld_tail), .ld_addr(ld_addr), .ld_result(ld_result), .ld_data(ld_data),
    .ld_tag(ld_tag), .deq_valid(deq_valid), .deq_ready(deq_ready),
    .deq_addr(deq_addr), .deq_data(deq_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_alloc(input logic [TAGW-1:0] t);
    alloc_valid = 1; alloc_tag = t; step(); alloc_valid = 0;
  endtask

  task automatic fill_addr(input int slot, input logic [AW-1:0] a);
    addr_valid = 1; addr_slot = IDXW'(slot); addr_value = a; step(); addr_valid = 0;
  endtask

  task automatic fill_data(input int slot, input logic [DW-1:0] d);
    data_valid = 1; data_slot = IDXW'(slot); data_value = d; step(); data_valid = 0;
  endtask

  task automatic query(input string req, input int tl, input logic [AW-1:0] a,
                       input logic [1:0] exp_res, input logic [63:0] exp_pay);
    ld_valid = 1; ld_tail = PTRW'(tl); ld_addr = a; #1;
    check(req, {62'd0, ld_result}, {62'd0, exp_res});
    if (exp_res == 2'd1) check(req, {32'd0, ld_data}, exp_pay);
    if (exp_res == 2'd2) check(req, {58'd0, ld_tag}, exp_pay);
    ld_valid = 0;
  endtask

  task automatic pop_one();
    deq_ready = 1; step(); deq_ready = 0;
  endtask

  task automatic t_reset();
    check("R1 alloc_ready", {63'd0, alloc_ready}, 64'd1);
    check("R1 deq_valid", {63'd0, deq_valid}, 64'd0);
    check("R1 tail_ptr", {60'd0, tail_ptr}, 64'd0);
    check("R1 idle result", {62'd0, ld_result}, 64'd0);
  endtask

  task automatic t_basic();
    do_alloc(6'd5); do_alloc(6'd6);           // slots 0,1; load recorded tail 2
    query("R4 unknown older addr", 2, 16'h100, 2'd3, 0);
    fill_addr(0, 16'h100);
    query("R4 stall despite match", 2, 16'h100, 2'd3, 0);
    fill_addr(1, 16'h200);
    query("R6 forward tag", 2, 16'h100, 2'd2, 64'd5);
    data_valid = 1; data_slot = 0; data_value = 32'hAAAA;
    query("R10 fill not yet visible", 2, 16'h100, 2'd2, 64'd5);
    step(); data_valid = 0;
    query("R5 forward value", 2, 16'h100, 2'd1, 64'hAAAA);
    query("R7 no match", 2, 16'h300, 2'd0, 0);
    query("R7 younger store ignored", 1, 16'h200, 2'd0, 0);
    query("R7 nothing older", 0, 16'h100, 2'd0, 0);
  endtask

  task automatic t_youngest();
    do_alloc(6'd7); fill_addr(2, 16'h100); fill_data(2, 32'hBBBB);
    query("R8 youngest older match", 3, 16'h100, 2'd1, 64'hBBBB);
    query("R8 older load sees first store", 2, 16'h100, 2'd1, 64'hAAAA);
    do_alloc(6'd8);                            // slot 3, address unknown
    query("R4 younger unknown no stall", 3, 16'h100, 2'd1, 64'hBBBB);
  endtask

  task automatic t_deq();
    #1;
    check("R3 head offered", {63'd0, deq_valid}, 64'd1);
    check("R3 head addr", {48'd0, deq_addr}, 64'h100);
    check("R3 head data", {32'd0, deq_data}, 64'hAAAA);
    pop_one();
    check("R3 head without data", {63'd0, deq_valid}, 64'd0);
    fill_data(1, 32'h1111);
    check("R3 in-order next", {32'd0, deq_data}, 64'h1111);
    pop_one();
    check("R3 third store", {32'd0, deq_data}, 64'hBBBB);
    pop_one();
    query("R7 dequeued stores ignored", 2, 16'h100, 2'd0, 0);
    fill_addr(3, 16'h900); fill_data(3, 32'h9);
    pop_one();
    check("R3 empty", {63'd0, deq_valid}, 64'd0);
  endtask

  task automatic t_wrap();
    // head=4, tail=4: ptrs 4..11 occupy slots 4..7 then 0..3
    for (int k = 0; k < DEPTH; k++) begin
      do_alloc(TAGW'(k));
      fill_addr((4 + k) % DEPTH, 16'h500);
      fill_data((4 + k) % DEPTH, 32'h700 + k);
    end
    check("R2 full ready", {63'd0, alloc_ready}, 64'd0);
    check("R2 tail wraps", {60'd0, tail_ptr}, 64'd12);
    do_alloc(6'd33);
    check("R2 alloc ignored when full", {60'd0, tail_ptr}, 64'd12);
    query("R9 across wrap", 10, 16'h500, 2'd1, 64'h705);
    query("R9 whole queue older", 12, 16'h500, 2'd1, 64'h707);
    query("R9 before wrap", 7, 16'h500, 2'd1, 64'h702);
    query("R9 tail equals head", 4, 16'h500, 2'd0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_youngest();
    t_deq();
    t_wrap();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule